// File: doc/BRIEF.md
# Reset Cause Capture Register

This block is one 8-bit special-function register that tells software which event produced the most recent system reset. It also lets software choose which of the optional reset sources may reset the chip. Seven raw events arrive at its inputs:

- power-on (asynchronous, active low)
- a supply-monitor trip
- the external reset pin
- a watchdog expiry
- a missing-clock timeout
- a comparator trip (active low)
- a flash access error

A write of 1 to the software-force bit acts as an eighth source. Each qualified event raises the system-reset output for a fixed number of clock cycles. On the first of those cycles the cause is latched as a one-hot flag.

Four bits have two meanings. A plain read shows the cause flags. A write sets the source enables. A read-modify-write access reads the stored enables instead of the flags, so that a bit update leaves the other enables as they were. The SFR port is a plain strobe interface with combinational read data. It has no valid/ready handshake, because every access completes in one cycle and cannot be back-pressured. The register answers only at its own address.

Top module: `rstcause_reg`

## Requirements
- R1: Only address 0xEF reads non-zero data; other addresses read 0x00. Bit 7 always reads 0, and any value written to it has no effect.
- R2: While `por_n` is low and for HOLD cycles after it rises, `sys_rst` is high. After power-on, a plain read gives 0x02. A read-modify-write read gives 0x02: the supply-monitor enable is on, and the comparator and missing-clock enables are off.
- R3: Plain-read flag positions are: bit 6 flash error, bit 5 comparator, bit 4 software force, bit 3 watchdog, bit 2 missing clock, bit 1 power-on/supply monitor, bit 0 pin. After every reset, exactly one of these flags is 1.
- R4: A write of 1 to bit 4 at the register address forces a reset, after which a plain read gives 0x10. A write of 0 to bit 4 causes no reset.
- R5: A low `cmp_n` causes a reset, flag 0x20, only while the comparator enable (write bit 5) is 1.
- R6: A high `mcd_timeout` causes a reset, flag 0x04, only while the missing-clock enable (write bit 2) is 1.
- R7: A high `vmon_trip` causes a reset, flag 0x02, only while the supply-monitor enable (write bit 1) is 1.
- R8: A read with `sfr_rmw` high returns {0, flash flag, comparator enable, 0, watchdog flag, missing-clock enable, supply-monitor enable, pin flag}.
- R9: A qualified event seen while `sys_rst` is low raises `sys_rst` from the next edge for exactly HOLD cycles, and the flag is updated on that same edge. Events and writes that arrive while `sys_rst` is high are ignored.
- R10: The three enables keep their values through every reset other than power-on.
- R11: When events coincide, the recorded cause follows this priority: supply monitor, pin, watchdog, missing clock, comparator, flash error, software force.
- R12: The pin (`pin_rst_n` low), watchdog and flash-error events always cause a reset, whatever the enables hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| vmon_trip | input | 1 | Supply-monitor trip event |
| pin_rst_n | input | 1 | External reset pin, active low |
| wdt_expire | input | 1 | Watchdog expiry event |
| mcd_timeout | input | 1 | Missing-clock timeout event |
| cmp_n | input | 1 | Comparator output, trip when low |
| flash_err | input | 1 | Flash access error event |
| sfr_addr | input | 8 | SFR address |
| sfr_wr | input | 1 | Write strobe |
| sfr_rmw | input | 1 | Marks a read-modify-write read |
| sfr_wdata | input | 8 | Write data |
| sfr_rdata | output | 8 | Read data, combinational |
| sys_rst | output | 1 | System reset request |

## Verification
The assertions assume that every event input is already synchronous to `clk`. They also assume that `por_n` is the only asynchronous input, so each event is judged on the edge where it is sampled. The bench drives all events and SFR strobes on the falling edge and holds them for one full cycle, which keeps within those assumptions. One assertion assumes that no other source is active while it watches a disabled comparator. The bench changes one source at a time, except in the priority sweep, where all enables are on.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;
  // cause index doubles as priority rank (0 wins)
  localparam int NCAUSE  = 7;
  localparam int C_VMON  = 0;
  localparam int C_PIN   = 1;
  localparam int C_WDT   = 2;
  localparam int C_MCD   = 3;
  localparam int C_CMP   = 4;
  localparam int C_FLASH = 5;
  localparam int C_SW    = 6;

  // register bit positions
  localparam int RW      = 8;
  localparam int B_PIN   = 0;
  localparam int B_VMON  = 1;
  localparam int B_MCD   = 2;
  localparam int B_WDT   = 3;
  localparam int B_SW    = 4;
  localparam int B_CMP   = 5;
  localparam int B_FLASH = 6;
  localparam int B_RSV   = 7;

  typedef struct packed {
    logic cmp;
    logic mcd;
    logic vmon;
  } src_en_t;

  function automatic int flag_bit(input int c);
    case (c)
      C_VMON:  return B_VMON;
      C_PIN:   return B_PIN;
      C_WDT:   return B_WDT;
      C_MCD:   return B_MCD;
      C_CMP:   return B_CMP;
      C_FLASH: return B_FLASH;
      default: return B_SW;
    endcase
  endfunction

  function automatic logic [RW-1:0] cause_flags(input logic [NCAUSE-1:0] w);
    logic [RW-1:0] f;
    f = '0;
    for (int c = 0; c < NCAUSE; c++)
      if (w[c]) f[flag_bit(c)] = 1'b1;
    return f;
  endfunction
endpackage

// File: rtl/rstcause_qual.sv
module rstcause_qual
  import rstcause_pkg::*;
(
  input  logic              vmon_trip,
  input  logic              pin_rst_n,
  input  logic              wdt_expire,
  input  logic              mcd_timeout,
  input  logic              cmp_n,
  input  logic              flash_err,
  input  logic              sw_force,
  input  src_en_t           en,
  output logic [NCAUSE-1:0] win
);
  logic [NCAUSE-1:0] req;

  always_comb begin
    req          = '0;
    req[C_VMON]  = vmon_trip & en.vmon;
    req[C_PIN]   = ~pin_rst_n;
    req[C_WDT]   = wdt_expire;
    req[C_MCD]   = mcd_timeout & en.mcd;
    req[C_CMP]   = ~cmp_n & en.cmp;
    req[C_FLASH] = flash_err;
    req[C_SW]    = sw_force;
  end

  // fixed priority: lowest index wins
  assign win[0] = req[0];
  genvar gi;
  generate
    for (gi = 1; gi < NCAUSE; gi++) begin : g_prio
      assign win[gi] = req[gi] & ~(|req[gi-1:0]);
    end
  endgenerate
endmodule

// File: rtl/rstcause_stretch.sv
module rstcause_stretch #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic trig,
  output logic sys_rst,
  output logic capture
);
  localparam int CW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] cnt;

  assign capture = trig & ~sys_rst;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      sys_rst <= 1'b1;
      cnt     <= LAST;
    end else if (capture) begin
      sys_rst <= 1'b1;
      cnt     <= LAST;
    end else if (sys_rst) begin
      if (cnt == '0) sys_rst <= 1'b0;
      else           cnt     <= cnt - 1'b1;
    end
  end

  p_trig_starts_r9: assert property (@(posedge clk) disable iff (!por_n)
    capture |=> sys_rst);
  p_hold_on_r9: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst && cnt != '0) |=> sys_rst);
  p_release_r9: assert property (@(posedge clk) disable iff (!por_n)
    (sys_rst && cnt == '0) |=> !sys_rst);
endmodule

// File: rtl/rstcause_store.sv
module rstcause_store
  import rstcause_pkg::*;
#(
  parameter logic [RW-1:0] ADDR = 8'hEF
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              in_rst,
  input  logic              capture,
  input  logic [NCAUSE-1:0] win,
  input  logic [7:0]        sfr_addr,
  input  logic              sfr_wr,
  input  logic              sfr_rmw,
  input  logic [RW-1:0]     sfr_wdata,
  output logic [RW-1:0]     sfr_rdata,
  output src_en_t           en,
  output logic              sw_force
);
  logic [RW-1:0] flg;
  logic [RW-1:0] rd_rmw;
  logic          hit;
  logic          wr_en;
  logic          unused_wdata;

  assign hit          = (sfr_addr == ADDR);
  assign wr_en        = hit & sfr_wr & ~in_rst;
  assign sw_force     = wr_en & sfr_wdata[B_SW];
  assign unused_wdata = ^{sfr_wdata[B_RSV], sfr_wdata[B_FLASH],
                          sfr_wdata[B_WDT], sfr_wdata[B_PIN]};

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      flg     <= RW'(1) << B_VMON;
      en.cmp  <= 1'b0;
      en.mcd  <= 1'b0;
      en.vmon <= 1'b1;
    end else begin
      if (capture) flg <= cause_flags(win);
      if (wr_en) begin
        en.cmp  <= sfr_wdata[B_CMP];
        en.mcd  <= sfr_wdata[B_MCD];
        en.vmon <= sfr_wdata[B_VMON];
      end
    end
  end

  always_comb begin
    rd_rmw         = flg;
    rd_rmw[B_CMP]  = en.cmp;
    rd_rmw[B_SW]   = 1'b0;
    rd_rmw[B_MCD]  = en.mcd;
    rd_rmw[B_VMON] = en.vmon;
    rd_rmw[B_RSV]  = 1'b0;
  end

  assign sfr_rdata = !hit ? '0 : (sfr_rmw ? rd_rmw : flg);

  p_one_flag_r3: assert property (@(posedge clk) disable iff (!por_n)
    $countones(flg) == 1);
  p_flags_frozen_r9: assert property (@(posedge clk) disable iff (!por_n)
    in_rst |=> $stable(flg));
  p_en_kept_r10: assert property (@(posedge clk) disable iff (!por_n)
    !wr_en |=> $stable(en));
  p_top_bit_zero_r1: assert property (@(posedge clk) disable iff (!por_n)
    sfr_rdata[B_RSV] == 1'b0);
endmodule

// File: rtl/rstcause_reg.sv
module rstcause_reg
  import rstcause_pkg::*;
#(
  parameter int             HOLD = 4,
  parameter logic [RW-1:0]  ADDR = 8'hEF
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          vmon_trip,
  input  logic          pin_rst_n,
  input  logic          wdt_expire,
  input  logic          mcd_timeout,
  input  logic          cmp_n,
  input  logic          flash_err,
  input  logic [7:0]    sfr_addr,
  input  logic          sfr_wr,
  input  logic          sfr_rmw,
  input  logic [RW-1:0] sfr_wdata,
  output logic [RW-1:0] sfr_rdata,
  output logic          sys_rst
);
  logic [NCAUSE-1:0] win;
  src_en_t           en;
  logic              sw_force;
  logic              capture;

  rstcause_qual u_qual (
    .vmon_trip  (vmon_trip),
    .pin_rst_n  (pin_rst_n),
    .wdt_expire (wdt_expire),
    .mcd_timeout(mcd_timeout),
    .cmp_n      (cmp_n),
    .flash_err  (flash_err),
    .sw_force   (sw_force),
    .en         (en),
    .win        (win)
  );

  rstcause_stretch #(.HOLD(HOLD)) u_stretch (
    .clk    (clk),
    .por_n  (por_n),
    .trig   (|win),
    .sys_rst(sys_rst),
    .capture(capture)
  );

  rstcause_store #(.ADDR(ADDR)) u_store (
    .clk      (clk),
    .por_n    (por_n),
    .in_rst   (sys_rst),
    .capture  (capture),
    .win      (win),
    .sfr_addr (sfr_addr),
    .sfr_wr   (sfr_wr),
    .sfr_rmw  (sfr_rmw),
    .sfr_wdata(sfr_wdata),
    .sfr_rdata(sfr_rdata),
    .en       (en),
    .sw_force (sw_force)
  );

  p_sw_force_r4: assert property (@(posedge clk) disable iff (!por_n)
    sw_force |=> sys_rst);
  p_cmp_gated_r5: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && !en.cmp && !cmp_n && !vmon_trip && pin_rst_n && !wdt_expire
     && !mcd_timeout && !flash_err && !sw_force) |=> !sys_rst);
  p_pin_always_r12: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst && !pin_rst_n) |=> sys_rst);
endmodule

// File: tb/rstcause_reg_bench.sv
module rstcause_reg_bench;
  localparam int HOLD = 4;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       vmon_trip = 1'b0, pin_rst_n = 1'b1, wdt_expire = 1'b0;
  logic       mcd_timeout = 1'b0, cmp_n = 1'b1, flash_err = 1'b0;
  logic [7:0] sfr_addr = 8'hEF, sfr_wdata = 8'h00, sfr_rdata;
  logic       sfr_wr = 1'b0, sfr_rmw = 1'b0, sys_rst;

  int errors = 0, checks = 0, nrst = 0;
  logic [7:0] exp_flags, enbits;
  bit finished = 0;

  always #2 clk = ~clk;

  rstcause_reg #(.HOLD(HOLD), .ADDR(8'hEF)) u_rstcause_reg (
    .clk(clk), .por_n(por_n), .vmon_trip(vmon_trip), .pin_rst_n(pin_rst_n),
    .wdt_expire(wdt_expire), .mcd_timeout(mcd_timeout), .cmp_n(cmp_n),
    .flash_err(flash_err), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
    .sfr_rmw(sfr_rmw), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata),
    .sys_rst(sys_rst));

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // cause index: 0 vmon,1 pin,2 wdt,3 mcd,4 cmp,5 flash,6 sw (priority order)
  function automatic logic [7:0] flag_of(input int c);
    case (c)
      0: return 8'h02; 1: return 8'h01; 2: return 8'h08; 3: return 8'h04;
      4: return 8'h20; 5: return 8'h40; default: return 8'h10;
    endcase
  endfunction

  function automatic bit enabled(input int c, input logic [7:0] e);
    case (c)
      0: return e[1]; 3: return e[2]; 4: return e[5];
      default: return 1'b1;
    endcase
  endfunction

  task automatic rd(input bit rmw, output logic [7:0] v);
    sfr_rmw = rmw; #1; v = sfr_rdata; sfr_rmw = 1'b0;
  endtask

  task automatic count_rst();
    nrst = 0;
    while (sys_rst && nrst < 50) begin nrst++; @(negedge clk); end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); sfr_wr = 1'b1; sfr_wdata = d;
    @(negedge clk); sfr_wr = 1'b0; sfr_wdata = 8'h00;
  endtask

  task automatic fire(input logic [6:0] m);
    @(negedge clk);
    vmon_trip = m[0]; pin_rst_n = ~m[1]; wdt_expire = m[2];
    mcd_timeout = m[3]; cmp_n = ~m[4]; flash_err = m[5];
    sfr_wr = m[6]; sfr_wdata = m[6] ? (enbits | 8'h10) : 8'h00;
    @(negedge clk);
    vmon_trip = 0; pin_rst_n = 1; wdt_expire = 0; mcd_timeout = 0;
    cmp_n = 1; flash_err = 0; sfr_wr = 0; sfr_wdata = 8'h00;
  endtask

  task automatic check_regs(input string tag);
    logic [7:0] v;
    rd(1'b0, v); chk(v, exp_flags, {tag, " R3 plain read"});
    rd(1'b1, v); chk(v, enbits | (exp_flags & 8'h49), {tag, " R8 rmw read"});
  endtask

  task automatic power_on();
    @(negedge clk); por_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    count_rst();
    chk(nrst, HOLD, "R2 power-on hold length");
    exp_flags = 8'h02; enbits = 8'h02;
    check_regs("R2 power-on");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    bit exp_r;
    power_on();

    // R1: foreign address reads zero, bit 7 write ignored
    sfr_addr = 8'h12; rd(1'b0, v); chk(v, 0, "R1 other address plain");
    rd(1'b1, v); chk(v, 0, "R1 other address rmw");
    wr(8'h10); chk(sys_rst, 0, "R1 force at other address ignored");
    sfr_addr = 8'hEF;
    wr(8'h80); enbits = 8'h00;
    chk(sys_rst, 0, "R1 bit7 write no reset");
    check_regs("R1 bit7 write");

    // sweep every enable setting against every single cause
    for (int e = 0; e < 8; e++) begin
      enbits = {2'b00, e[2], 2'b00, e[1], e[0], 1'b0};
      wr(enbits);
      chk(sys_rst, 0, "R4 write of 0 to force bit no reset");
      check_regs("R10 enables written");
      for (int c = 0; c < 7; c++) begin
        fire(7'(1 << c));
        exp_r = enabled(c, enbits);
        chk(sys_rst, exp_r, $sformatf("R5 R6 R7 R12 cause %0d en %0h reset", c, enbits));
        if (exp_r) begin
          count_rst();
          chk(nrst, HOLD, $sformatf("R9 hold length cause %0d", c));
          exp_flags = flag_of(c);
        end
        check_regs($sformatf("R4 R10 cause %0d en %0h", c, enbits));
      end
    end

    // priority over every pair with all enables on
    enbits = 8'h26; wr(enbits);
    for (int i = 0; i < 6; i++)
      for (int j = i + 1; j < 7; j++) begin
        fire(7'((1 << i) | (1 << j)));
        count_rst();
        chk(nrst, HOLD, "R11 pair hold length");
        exp_flags = flag_of(i);
        check_regs($sformatf("R11 pair %0d,%0d", i, j));
      end

    // R9: events and writes during reset are ignored
    @(negedge clk); wdt_expire = 1'b1;
    @(negedge clk); wdt_expire = 1'b0;
    chk(sys_rst, 1, "R9 watchdog starts reset");
    nrst = 1;
    @(negedge clk); nrst++;
    pin_rst_n = 1'b0; sfr_wr = 1'b1; sfr_wdata = 8'h10;
    @(negedge clk); nrst++;
    pin_rst_n = 1'b1; sfr_wr = 1'b0; sfr_wdata = 8'h00;
    while (sys_rst && nrst < 50) begin @(negedge clk); if (sys_rst) nrst++; end
    chk(nrst, HOLD, "R9 no retrigger during reset");
    exp_flags = 8'h08;
    check_regs("R9 ignored during reset");

    // second power-on clears enables to their defaults
    power_on();

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule